// File: doc/BRIEF.md
# Flag Register and Branch Evaluator

This block keeps the five status flags of a small processor core: overflow, carry, zero, negative and interrupt enable. It decodes one opcode per cycle from the issue stage. Dedicated opcodes set or clear one flag each, and two reserved opcode windows are reported as illegal. Conditional jump opcodes are resolved against the current flags. The arithmetic unit can also write the four arithmetic flags through a separate write-enable port.

All outputs are registered. An opcode presented with `op_valid` at a rising edge shows its effect on `flags`, `br_taken`, `br_target` and `illegal` in the following cycle. A jump is decided on the flags as they stood before that edge, so an arithmetic flag write in the same cycle affects only later jumps. The branch target is the operand already resolved upstream and is passed through unchanged. The asynchronous active-low reset is released through a synchronizer inside the block.

Flag vector bit positions: bit 0 overflow, bit 1 carry, bit 2 zero, bit 3 negative, bit 4 interrupt enable.

Top module: `flag_branch_unit`

## Requirements
- R1: During reset and after its release, `flags` is 5'b00000 and `br_taken`, `br_target` and `illegal` are zero.
- R2: A valid opcode 0x2b+i (i = 0..4) clears flag bit i in the next cycle.
- R3: A valid opcode 0x3b+i (i = 0..4) sets flag bit i in the next cycle.
- R4: A valid opcode in 0x30..0x3a or 0x40..0x4a raises `illegal` for exactly the next cycle. The opcode itself changes no flag.
- R5: When `alu_we` is high, `alu_flags[3:0]` (overflow, carry, zero, negative) is loaded into `flags[3:0]` in the next cycle, and the interrupt enable bit keeps its value.
- R6: When a set or clear opcode and an ALU write fall in the same cycle, the opcode decides its own flag and the ALU value decides the other arithmetic flags.
- R7: A valid opcode 0x10 is always taken.
- R8: 0x11 is taken when zero=1, and 0x18 is taken when zero=0.
- R9: 0x12 is taken when zero=0 and negative=overflow. 0x13 is taken when negative=overflow. 0x14 is taken when negative differs from overflow. 0x15 is taken when zero=1 or negative differs from overflow.
- R10: 0x16 is taken when carry=1, 0x19 when carry=0, 0x17 when negative=1, and 0x1a when negative=0.
- R11: `br_taken` is high for one cycle after a taken jump, and `br_target` then holds the operand given with that jump. `br_target` is zero whenever `br_taken` is low.
- R12: A jump is decided on the flags held before the edge at which it is sampled. An ALU write in the same cycle does not change that decision.
- R13: With `op_valid` low, or with any opcode outside the flag and jump ranges, no flag changes except by ALU write, and `br_taken` and `illegal` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode is presented this cycle |
| opcode | input | 8 | Opcode being issued |
| operand | input | ADDR_W | Resolved jump destination |
| alu_we | input | 1 | Write arithmetic flags from the ALU |
| alu_flags | input | 4 | ALU flag values: overflow, carry, zero, negative |
| flags | output | 5 | Current flag vector |
| br_taken | output | 1 | Jump of the previous cycle is taken |
| br_target | output | ADDR_W | Destination of the taken jump |
| illegal | output | 1 | Previous opcode was reserved |

## Verification
Two functions can land on the same edge. The first is an arithmetic flag write that meets a set or clear opcode. The second is an arithmetic flag write that meets a conditional jump. The bench provokes the first by pairing each set and clear opcode with ALU values that oppose it, and expects the opcode to win for its own bit only. It provokes the second by issuing jumps together with ALU writes that would flip the condition, and expects the decision to follow the old flags while the new flags appear one cycle later.

// File: rtl/fbu_pkg.sv
package fbu_pkg;
  localparam int FLAG_CNT  = 5;
  localparam int ARITH_CNT = 4;

  localparam int F_OV = 0;
  localparam int F_CY = 1;
  localparam int F_ZR = 2;
  localparam int F_NG = 3;
  localparam int F_IE = 4;

  localparam logic [7:0] CLR_BASE  = 8'h2b;
  localparam logic [7:0] SET_BASE  = 8'h3b;
  localparam logic [7:0] RSV0_LO   = 8'h30;
  localparam logic [7:0] RSV0_HI   = 8'h3a;
  localparam logic [7:0] RSV1_LO   = 8'h40;
  localparam logic [7:0] RSV1_HI   = 8'h4a;
  localparam logic [7:0] JUMP_LO   = 8'h10;
  localparam logic [7:0] JUMP_HI   = 8'h1a;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'h0,
    C_ZERO   = 4'h1,
    C_GT     = 4'h2,
    C_GE     = 4'h3,
    C_LT     = 4'h4,
    C_LE     = 4'h5,
    C_CARRY  = 4'h6,
    C_NEG    = 4'h7,
    C_NZERO  = 4'h8,
    C_NCARRY = 4'h9,
    C_NNEG   = 4'ha
  } cond_e;
endpackage

// File: rtl/fbu_rst_sync.sv
module fbu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fbu_decode.sv
module fbu_decode
  import fbu_pkg::*;
(
  input  logic                op_valid,
  input  logic [7:0]          opcode,
  output logic [FLAG_CNT-1:0] set_mask,
  output logic [FLAG_CNT-1:0] clr_mask,
  output logic                is_jump,
  output cond_e               cond,
  output logic                is_rsv
);
  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_mask
    localparam logic [7:0] SET_OP = SET_BASE + 8'(i);
    localparam logic [7:0] CLR_OP = CLR_BASE + 8'(i);
    assign set_mask[i] = op_valid && (opcode == SET_OP);
    assign clr_mask[i] = op_valid && (opcode == CLR_OP);
  end

  always_comb begin
    is_jump = op_valid && (opcode >= JUMP_LO) && (opcode <= JUMP_HI);
    cond    = cond_e'(opcode[3:0]);
    is_rsv  = op_valid &&
              (((opcode >= RSV0_LO) && (opcode <= RSV0_HI)) ||
               ((opcode >= RSV1_LO) && (opcode <= RSV1_HI)));
  end
endmodule

// File: rtl/fbu_flag_store.sv
module fbu_flag_store
  import fbu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [FLAG_CNT-1:0]  set_mask,
  input  logic [FLAG_CNT-1:0]  clr_mask,
  input  logic                 alu_we,
  input  logic [ARITH_CNT-1:0] alu_flags,
  output logic [FLAG_CNT-1:0]  flags_q
);
  logic [FLAG_CNT-1:0] flags_d;
  logic [FLAG_CNT-1:0] flag_en;

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_bit
    if (i < ARITH_CNT) begin : g_arith
      assign flag_en[i] = set_mask[i] | clr_mask[i] | alu_we;
      assign flags_d[i] = set_mask[i] ? 1'b1 :
                          clr_mask[i] ? 1'b0 : alu_flags[i];
    end else begin : g_ctrl
      assign flag_en[i] = set_mask[i] | clr_mask[i];
      assign flags_d[i] = set_mask[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[i] <= 1'b0;
      else if (flag_en[i]) flags_q[i] <= flags_d[i];
    end
  end
endmodule

// File: rtl/fbu_branch.sv
module fbu_branch
  import fbu_pkg::*;
(
  input  logic [ARITH_CNT-1:0] fl,
  input  cond_e                cond,
  output logic                 met
);
  logic sgn_eq;

  always_comb begin
    sgn_eq = (fl[F_NG] == fl[F_OV]);
    unique case (cond)
      C_ALWAYS: met = 1'b1;
      C_ZERO:   met = fl[F_ZR];
      C_GT:     met = !fl[F_ZR] && sgn_eq;
      C_GE:     met = sgn_eq;
      C_LT:     met = !sgn_eq;
      C_LE:     met = fl[F_ZR] || !sgn_eq;
      C_CARRY:  met = fl[F_CY];
      C_NEG:    met = fl[F_NG];
      C_NZERO:  met = !fl[F_ZR];
      C_NCARRY: met = !fl[F_CY];
      C_NNEG:   met = !fl[F_NG];
      default:  met = 1'b0;
    endcase
  end
endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import fbu_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RST_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [7:0]           opcode,
  input  logic [ADDR_W-1:0]    operand,
  input  logic                 alu_we,
  input  logic [ARITH_CNT-1:0] alu_flags,
  output logic [FLAG_CNT-1:0]  flags,
  output logic                 br_taken,
  output logic [ADDR_W-1:0]    br_target,
  output logic                 illegal
);
  logic                rst_int_n;
  logic [FLAG_CNT-1:0] set_mask, clr_mask, flags_q;
  logic                is_jump, is_rsv, met;
  cond_e               cond;
  logic                take_d, ill_d;
  logic [ADDR_W-1:0]   tgt_d;

  fbu_rst_sync #(.STAGES(RST_STAGES)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  fbu_decode i_dec (
    .op_valid(op_valid), .opcode(opcode), .set_mask(set_mask),
    .clr_mask(clr_mask), .is_jump(is_jump), .cond(cond), .is_rsv(is_rsv)
  );

  fbu_flag_store i_store (
    .clk(clk), .rst_n(rst_int_n), .set_mask(set_mask), .clr_mask(clr_mask),
    .alu_we(alu_we), .alu_flags(alu_flags), .flags_q(flags_q)
  );

  fbu_branch i_br (
    .fl(flags_q[ARITH_CNT-1:0]), .cond(cond), .met(met)
  );

  always_comb begin
    take_d = is_jump && met;
    tgt_d  = take_d ? operand : '0;
    ill_d  = is_rsv;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      br_taken  <= 1'b0;
      br_target <= '0;
      illegal   <= 1'b0;
    end else begin
      br_taken  <= take_d;
      br_target <= tgt_d;
      illegal   <= ill_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/fbu_checker.sv
module fbu_checker
  import fbu_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 op_valid,
  input logic [7:0]           opcode,
  input logic [ADDR_W-1:0]    operand,
  input logic                 alu_we,
  input logic [ARITH_CNT-1:0] alu_flags,
  input logic [FLAG_CNT-1:0]  flags,
  input logic                 br_taken,
  input logic [ADDR_W-1:0]    br_target,
  input logic                 illegal
);
  logic rsv_op;
  assign rsv_op = op_valid &&
                  (((opcode >= 8'h30) && (opcode <= 8'h3a)) ||
                   ((opcode >= 8'h40) && (opcode <= 8'h4a)));

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    a_r2_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 8'(8'h2b + i)) |=> !flags[i]);
    a_r3_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && opcode == 8'(8'h3b + i)) |=> flags[i]);
  end

  a_r4_rsv_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (rsv_op && !alu_we) |=> ($stable(flags) && illegal));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!br_taken && !illegal));

  a_r5_ie_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && !(op_valid && (opcode == 8'h2f || opcode == 8'h3f)))
      |=> $stable(flags[4]));

  a_r7_jmp_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 8'h10) |=> br_taken);

  a_r11_target: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (br_target == $past(operand)));

  a_r11_target_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |-> (br_target == '0));
endmodule

bind flag_branch_unit fbu_checker #(.ADDR_W(ADDR_W)) i_fbu_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .operand(operand), .alu_we(alu_we), .alu_flags(alu_flags), .flags(flags),
  .br_taken(br_taken), .br_target(br_target), .illegal(illegal)
);

// File: tb/test_flag_branch_unit.sv
module test_flag_branch_unit;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          op_valid;
  logic [7:0]    opcode;
  logic [AW-1:0] operand;
  logic          alu_we;
  logic [3:0]    alu_flags;
  logic [4:0]    flags;
  logic          br_taken;
  logic [AW-1:0] br_target;
  logic          illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [4:0]    m_flags = '0;
  logic          m_taken = 0;
  logic [AW-1:0] m_tgt   = '0;
  logic          m_ill   = 0;

  always #10 clk = ~clk;

  flag_branch_unit #(.ADDR_W(AW)) i_flag_branch_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .operand(operand), .alu_we(alu_we), .alu_flags(alu_flags),
    .flags(flags), .br_taken(br_taken), .br_target(br_target),
    .illegal(illegal)
  );

  function automatic bit jump_ok(input int op, input logic [4:0] f);
    bit o = f[0], c = f[1], z = f[2], n = f[3];
    if (op == 16'h10) return 1;
    if (op == 16'h11) return z;
    if (op == 16'h12) return !z && (n == o);
    if (op == 16'h13) return n == o;
    if (op == 16'h14) return n != o;
    if (op == 16'h15) return z || (n != o);
    if (op == 16'h16) return c;
    if (op == 16'h17) return n;
    if (op == 16'h18) return !z;
    if (op == 16'h19) return !c;
    if (op == 16'h1a) return !n;
    return 0;
  endfunction

  function automatic string jump_tag(input int op);
    if (op == 16'h10) return "R7";
    if (op == 16'h11 || op == 16'h18) return "R8";
    if (op >= 16'h12 && op <= 16'h15) return "R9";
    return "R10";
  endfunction

  task automatic compare(input string tag);
    total++;
    if (flags !== m_flags || br_taken !== m_taken ||
        br_target !== m_tgt || illegal !== m_ill) begin
      bad++;
      $display("FAIL %s: flags=%b taken=%b tgt=%h ill=%b expected flags=%b taken=%b tgt=%h ill=%b",
               tag, flags, br_taken, br_target, illegal,
               m_flags, m_taken, m_tgt, m_ill);
    end
  endtask

  task automatic step(input bit v, input int op, input logic [AW-1:0] opd,
                      input bit we, input logic [3:0] af, input string tag);
    logic [4:0] nf;
    op_valid = v; opcode = 8'(op); operand = opd; alu_we = we; alu_flags = af;
    @(posedge clk);
    m_taken = v && (op >= 16'h10) && (op <= 16'h1a) && jump_ok(op, m_flags);
    m_tgt   = m_taken ? opd : '0;
    m_ill   = v && (((op >= 16'h30) && (op <= 16'h3a)) ||
                    ((op >= 16'h40) && (op <= 16'h4a)));
    nf = m_flags;
    if (we) nf[3:0] = af;
    for (int i = 0; i < 5; i++) begin
      if (v && op == 16'h3b + i) nf[i] = 1'b1;
      if (v && op == 16'h2b + i) nf[i] = 1'b0;
    end
    m_flags = nf;
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; op_valid = 0; opcode = '0; operand = '0; alu_we = 0; alu_flags = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    for (int k = 0; k < 4; k++) step(0, 0, '0, 0, 4'h0, "R1");

    // R3: set each flag
    for (int i = 0; i < 5; i++) step(1, 16'h3b + i, '0, 0, 4'h0, "R3");
    // R2: clear each flag
    for (int i = 0; i < 5; i++) step(1, 16'h2b + i, '0, 0, 4'h0, "R2");

    // R4: reserved windows with a mixed flag pattern
    step(1, 16'h3c, '0, 0, 4'h0, "R3");
    step(1, 16'h3f, '0, 0, 4'h0, "R3");
    for (int op = 16'h30; op <= 16'h3a; op++) step(1, op, '0, 0, 4'h0, "R4");
    for (int op = 16'h40; op <= 16'h4a; op++) step(1, op, '0, 0, 4'h0, "R4");
    step(1, 16'h3a, '0, 1, 4'ha, "R4");

    // R5: ALU writes keep IE
    step(0, 0, '0, 1, 4'h5, "R5");
    step(0, 0, '0, 1, 4'hf, "R5");
    step(1, 16'h2f, '0, 0, 4'h0, "R2");
    step(0, 0, '0, 1, 4'h0, "R5");
    step(0, 0, '0, 1, 4'h9, "R5");

    // R6: opcode beats ALU for its own flag
    for (int i = 0; i < 4; i++) step(1, 16'h3b + i, '0, 1, 4'h0, "R6");
    for (int i = 0; i < 4; i++) step(1, 16'h2b + i, '0, 1, 4'hf, "R6");
    step(1, 16'h3f, '0, 1, 4'h3, "R6");
    step(1, 16'h2f, '0, 1, 4'hc, "R6");

    // R7..R11: every jump under every arithmetic flag pattern
    for (int p = 0; p < 16; p++) begin
      step(0, 0, '0, 1, 4'(p), "R5");
      for (int op = 16'h10; op <= 16'h1a; op++)
        step(1, op, AW'(16'h1000 + p * 16 + op), 0, 4'h0, jump_tag(op));
    end
    step(1, 16'h10, 16'hffff, 0, 4'h0, "R11");
    step(1, 16'h10, 16'h0000, 0, 4'h0, "R11");

    // R12: jump with a same-cycle ALU write that flips the condition
    step(0, 0, '0, 1, 4'h4, "R5");
    step(1, 16'h11, 16'h0abc, 1, 4'h0, "R12");
    step(1, 16'h11, 16'h0abd, 0, 4'h0, "R12");
    step(1, 16'h16, 16'h0123, 1, 4'h2, "R12");
    step(1, 16'h16, 16'h0124, 1, 4'h0, "R12");
    step(1, 16'h14, 16'h0200, 1, 4'h1, "R12");
    step(1, 16'h14, 16'h0201, 0, 4'h0, "R12");

    // R13: non-flag, non-jump opcodes and idle jumps
    step(0, 16'h10, 16'h5555, 0, 4'h0, "R13");
    step(0, 16'h3d, '0, 0, 4'h0, "R13");
    step(0, 16'h35, '0, 0, 4'h0, "R13");
    step(1, 16'h00, 16'h7777, 0, 4'h0, "R13");
    step(1, 16'h0f, 16'h7777, 0, 4'h0, "R13");
    step(1, 16'h1b, 16'h7777, 0, 4'h0, "R13");
    step(1, 16'h2a, 16'h7777, 0, 4'h0, "R13");
    step(1, 16'h4b, 16'h7777, 0, 4'h0, "R13");
    step(1, 16'h4d, 16'h7777, 1, 4'h6, "R13");
    step(1, 16'hff, 16'h7777, 0, 4'h0, "R13");

    // R1: reset mid-run returns to zero
    step(1, 16'h3f, '0, 1, 4'hf, "R3");
    rst_n = 0;
    m_flags = '0; m_taken = 0; m_tgt = '0; m_ill = 0;
    @(negedge clk);
    compare("R1");
    rst_n = 1;
    for (int k = 0; k < 3; k++) step(0, 0, '0, 0, 4'h0, "R1");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule